// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 32 interrupt lines. It holds a pending bit, an enable bit, a priority, a trigger type and a vector for each line. It drives one active-low request to the processor. A simple word-addressed register bus lets software program each source, turn sources on and off with write-one commands, and force or drop pending state. Software then reads a vector register. That read returns the vector of the most urgent enabled pending source.

The vector read changes state. It records the winning source as the one now in service and pushes that source's priority onto an eight-level nesting stack. While the entry sits on the stack, only a source of strictly higher priority can raise the request again. An end-of-interrupt write removes the top entry. If no source qualifies when the vector is read, the read returns a programmable spurious vector and the stack is left as it was.

Top module: `vec_irq_ctrl`

Register word addresses (byte offset / 4):

| Word address | Access | Meaning |
|---|---|---|
| 0x00 + n | read/write | mode of source n |
| 0x20 + n | read/write | vector of source n |
| 0x40 | read | acknowledge read (vector of the winning source) |
| 0x42 | read | number of the source in service |
| 0x43 | read | pending bits |
| 0x44 | read | enable mask |
| 0x48 | write | enable command |
| 0x49 | write | disable command |
| 0x4A | write | pending clear command |
| 0x4B | write | pending set command |
| 0x4C | write | end of interrupt |
| 0x4D | read/write | spurious vector |

## Requirements
- R1: Mode and vector registers read back what was written. A mode register keeps only priority bits [2:0] and trigger bits [6:5]; its other bits read as 0. The spurious vector register is a full 32-bit read/write register. Read data appears on bus_rdata on the clock edge after the read cycle.
- R2: A write of 1 to a bit of the enable command sets that bit of the mask. A write of 1 to a bit of the disable command clears it. Bits written as 0 leave the mask unchanged. A disabled source never drives irq_n and is never chosen by the acknowledge read.
- R3: A 1 in the set command makes that source pending. A 1 in the clear command removes latched pending state.
- R4: Trigger code 3 (rising edge) and code 1 (falling edge) latch pending on the matching transition of the line. The opposite transition has no effect. An acknowledge read that selects an edge source clears its pending bit, even while the line stays at its new level.
- R5: For trigger code 2 (high level) and code 0 (low level), the pending bit follows the line: it is set while the line is at the active level and clear once the line leaves it. An acknowledge read does not clear the pending bit while the line remains active.
- R6: Among enabled pending sources, the highest priority wins (7 highest, 0 lowest). When priorities are equal, the lower source number wins. The acknowledge read returns the winner's vector.
- R7: irq_n is low exactly when the winner's priority is strictly above the priority on top of the stack. When the stack is empty, irq_n is low when any source is enabled and pending.
- R8: A successful acknowledge read pushes the winner onto the stack. The in-service register then returns the winner's number, and it returns 0 when the stack is empty.
- R9: An end-of-interrupt write pops one level. Eight such writes always leave the stack empty. Writes made when the stack is already empty change nothing.
- R10: When no source beats the top of the stack, the acknowledge read returns the spurious vector and does not push.
- R11: Reset clears the mask, the latched pending bits, the stack, all mode and vector registers and the spurious vector. It also drives irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| irq_line | input | 32 | interrupt source lines, synchronous to clk |
| bus_sel | input | 1 | bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid the cycle after the read |
| irq_n | output | 1 | active-low interrupt request |

## Verification
The bench checks the strict-greater rule at a full stack. A second source at the top priority must not raise irq_n, and its acknowledge read must return the spurious vector; a design that compares with greater-or-equal would nest a ninth level and corrupt the stack. The bench also drives patterns in which priorities tie; a scan in the wrong direction would hand the higher-numbered source to software. For edge sources whose line stays high after acknowledge, the bench expects pending to clear, where a design that lets pending follow the level would re-interrupt forever. For level sources the bench expects pending to survive the acknowledge. Eight end-of-interrupt writes from a partly filled stack, followed by extra writes on an empty stack, catch an underflow that would wrap the counter and lock the request out.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] A_ACK_READ = 8'h40;
    localparam logic [BUS_AW-1:0] A_IN_SVC   = 8'h42;
    localparam logic [BUS_AW-1:0] A_PENDING  = 8'h43;
    localparam logic [BUS_AW-1:0] A_MASK     = 8'h44;
    localparam logic [BUS_AW-1:0] A_EN_CMD   = 8'h48;
    localparam logic [BUS_AW-1:0] A_DIS_CMD  = 8'h49;
    localparam logic [BUS_AW-1:0] A_CLR_CMD  = 8'h4A;
    localparam logic [BUS_AW-1:0] A_SET_CMD  = 8'h4B;
    localparam logic [BUS_AW-1:0] A_EOI      = 8'h4C;
    localparam logic [BUS_AW-1:0] A_SPUR     = 8'h4D;

    localparam int MODE_TRIG_LSB = 5;

    // bit 0 selects edge, bit 1 selects the active polarity
    typedef enum logic [1:0] {
        TRIG_LEVEL_LOW  = 2'd0,
        TRIG_EDGE_FALL  = 2'd1,
        TRIG_LEVEL_HIGH = 2'd2,
        TRIG_EDGE_RISE  = 2'd3
    } trig_e;
endpackage

// File: rtl/vic_src_pend.sv
module vic_src_pend #(
    parameter int NUM_SRC = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      line_i,
    input  logic [NUM_SRC-1:0][1:0] trig_i,
    input  logic [NUM_SRC-1:0]      set_i,
    input  logic [NUM_SRC-1:0]      clr_i,
    input  logic [NUM_SRC-1:0]      ack_i,
    output logic [NUM_SRC-1:0]      pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] latch;
        logic [NUM_SRC-1:0] prev;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NUM_SRC-1:0] is_edge, edge_hit, lvl_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign is_edge[g]  = trig_i[g][0];
        assign lvl_hit[g]  = ~is_edge[g] & (trig_i[g][1] ? line_i[g] : ~line_i[g]);
        assign edge_hit[g] = is_edge[g] & (trig_i[g][1] ? (line_i[g] & ~st_q.prev[g])
                                                        : (~line_i[g] & st_q.prev[g]));
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = line_i;
        st_d.latch = (st_q.latch & ~clr_i & ~ack_i) | set_i | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.latch | lvl_hit;

    // an acknowledged edge source drops its latch unless re-armed that cycle
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_i & is_edge)) |=> ((st_q.latch & $past(ack_i & is_edge & ~set_i & ~edge_hit)) == '0));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           valid_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [PRIO_W-1:0]              prio_o
);
    logic              v;
    logic [IDX_W-1:0]  ix;
    logic [PRIO_W-1:0] px;

    // downward scan with >= leaves the lowest index on ties
    always_comb begin
        v  = 1'b0;
        ix = '0;
        px = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i] && (!v || prio_i[i] >= px)) begin
                v  = 1'b1;
                ix = IDX_W'(i);
                px = prio_i[i];
            end
        end
    end

    assign valid_o = v;
    assign idx_o   = ix;
    assign prio_o  = px;
endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic [IDX_W-1:0]  push_src_i,
    input  logic              pop_i,
    output logic              empty_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [IDX_W-1:0]  top_src_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] prio;
        logic [DEPTH-1:0][IDX_W-1:0]  src;
        logic [CNT_W-1:0]             cnt;
    } nest_st_t;

    nest_st_t st_d, st_q;
    logic [PTR_W-1:0] wr_ptr, top_ptr;

    assign wr_ptr  = PTR_W'(st_q.cnt);
    assign top_ptr = PTR_W'(st_q.cnt - 1'b1);

    always_comb begin
        st_d = st_q;
        if (push_i && st_q.cnt < CNT_W'(DEPTH)) begin
            st_d.prio[wr_ptr] = push_prio_i;
            st_d.src[wr_ptr]  = push_src_i;
            st_d.cnt          = st_q.cnt + 1'b1;
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty_o    = (st_q.cnt == '0);
    assign top_prio_o = empty_o ? '0 : st_q.prio[top_ptr];
    assign top_src_o  = empty_o ? '0 : st_q.src[top_ptr];
    assign count_o    = st_q.cnt;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_o < CNT_W'(DEPTH)));

    assert_push_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_src_o == $past(push_src_i) && top_prio_o == $past(push_prio_i)));

    assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int PRIO_W  = 3,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_line,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [BUS_AW-1:0] VEC_BASE = BUS_AW'(NUM_SRC);
    localparam logic [BUS_AW-1:0] VEC_END  = BUS_AW'(2 * NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0][1:0]        trig;
        logic [NUM_SRC-1:0][DATA_W-1:0] vec;
        logic [NUM_SRC-1:0]             mask;
        logic [DATA_W-1:0]              spur;
        logic [DATA_W-1:0]              rdata;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic               wr_cyc, rd_cyc, ack_rd, take, pop, irq_ok;
    logic               mode_hit, vec_hit;
    logic [IDX_W-1:0]   mode_idx, vec_idx;
    logic [NUM_SRC-1:0] set_cmd, clr_cmd, ack_vec, pend, req;
    logic               arb_valid;
    logic [IDX_W-1:0]   arb_idx;
    logic [PRIO_W-1:0]  arb_prio;
    logic               stk_empty;
    logic [PRIO_W-1:0]  stk_prio;
    logic [IDX_W-1:0]   stk_src;
    logic [CNT_W-1:0]   stk_cnt;

    // bus decode
    assign wr_cyc   = bus_sel & bus_we;
    assign rd_cyc   = bus_sel & ~bus_we;
    assign mode_hit = (bus_addr < VEC_BASE);
    assign vec_hit  = (bus_addr >= VEC_BASE) && (bus_addr < VEC_END);
    assign mode_idx = IDX_W'(bus_addr);
    assign vec_idx  = IDX_W'(bus_addr - VEC_BASE);
    assign ack_rd   = rd_cyc && (bus_addr == A_ACK_READ);
    assign pop      = wr_cyc && (bus_addr == A_EOI);
    assign set_cmd  = (wr_cyc && bus_addr == A_SET_CMD) ? NUM_SRC'(bus_wdata) : '0;
    assign clr_cmd  = (wr_cyc && bus_addr == A_CLR_CMD) ? NUM_SRC'(bus_wdata) : '0;

    // arbitration against the nesting level
    assign req     = pend & st_q.mask;
    assign irq_ok  = arb_valid && (stk_empty || arb_prio > stk_prio);
    assign take    = ack_rd && irq_ok;
    assign ack_vec = take ? (NUM_SRC'(1) << arb_idx) : '0;
    assign irq_n   = ~irq_ok;

    vic_src_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (irq_line),
        .trig_i (st_q.trig),
        .set_i  (set_cmd),
        .clr_i  (clr_cmd),
        .ack_i  (ack_vec),
        .pend_o (pend)
    );

    vic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req_i   (req),
        .prio_i  (st_q.prio),
        .valid_o (arb_valid),
        .idx_o   (arb_idx),
        .prio_o  (arb_prio)
    );

    vic_nest #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_nest (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take),
        .push_prio_i (arb_prio),
        .push_src_i  (arb_idx),
        .pop_i       (pop),
        .empty_o     (stk_empty),
        .top_prio_o  (stk_prio),
        .top_src_o   (stk_src),
        .count_o     (stk_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_cyc) begin
            if (mode_hit) begin
                st_d.prio[mode_idx] = bus_wdata[PRIO_W-1:0];
                st_d.trig[mode_idx] = bus_wdata[MODE_TRIG_LSB +: 2];
            end
            if (vec_hit)
                st_d.vec[vec_idx] = bus_wdata;
            if (bus_addr == A_EN_CMD)
                st_d.mask = st_q.mask | NUM_SRC'(bus_wdata);
            if (bus_addr == A_DIS_CMD)
                st_d.mask = st_q.mask & ~NUM_SRC'(bus_wdata);
            if (bus_addr == A_SPUR)
                st_d.spur = bus_wdata;
        end
        if (rd_cyc) begin
            st_d.rdata = '0;
            if (mode_hit) begin
                st_d.rdata[PRIO_W-1:0]          = st_q.prio[mode_idx];
                st_d.rdata[MODE_TRIG_LSB +: 2]  = st_q.trig[mode_idx];
            end else if (vec_hit) begin
                st_d.rdata = st_q.vec[vec_idx];
            end else begin
                case (bus_addr)
                    A_ACK_READ: st_d.rdata = take ? st_q.vec[arb_idx] : st_q.spur;
                    A_IN_SVC:   st_d.rdata = DATA_W'(stk_src);
                    A_PENDING:  st_d.rdata = DATA_W'(pend);
                    A_MASK:     st_d.rdata = DATA_W'(st_q.mask);
                    A_SPUR:     st_d.rdata = st_q.spur;
                    default:    st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> irq_n);

    assert_win_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> req[arb_idx]);

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == A_EN_CMD) |=>
            ((st_q.mask & $past(NUM_SRC'(bus_wdata))) == $past(NUM_SRC'(bus_wdata))));

    assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == A_DIS_CMD) |=> ((st_q.mask & $past(NUM_SRC'(bus_wdata))) == '0));

    assert_spurious_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_n) |=> (bus_rdata == $past(st_q.spur) && stk_cnt == $past(stk_cnt)));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    localparam logic [7:0] W_ACK = 8'h40, W_CUR = 8'h42, W_PEND = 8'h43, W_MASK = 8'h44;
    localparam logic [7:0] W_EN = 8'h48, W_DIS = 8'h49, W_CLR = 8'h4A, W_SET = 8'h4B;
    localparam logic [7:0] W_EOI = 8'h4C, W_SPUR = 8'h4D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '1;
    logic        sel = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_line(lines), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int pr(input int i);
        return (i * 5 + 3) % 8;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic int winner(input logic [31:0] p, input logic [31:0] m);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < 32; i++)
            if (p[i] && m[i] && pr(i) > bp) begin
                best = i;
                bp = pr(i);
            end
        return best;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, model, x, pat;
        logic [31:0] spur;
        int src_of[8];
        int w, s7b;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11 irq_n", {31'b0, irq_n}, 32'h1);
        rd(8'd5, v);   check("R11 mode", v, 0);
        rd(8'd39, v);  check("R11 vector", v, 0);
        rd(W_MASK, v); check("R11 mask", v, 0);
        rd(W_PEND, v); check("R11 pending", v, 0);
        rd(W_CUR, v);  check("R11 in-service", v, 0);
        rd(W_SPUR, v); check("R11 spurious", v, 0);
        rd(W_ACK, v);  check("R10 ack read at reset", v, 0);

        // R1 register sweep
        for (int i = 0; i < 32; i++) begin
            wr(8'(i), 32'hFFFFFF80 ^ (i * 32'h01010101) ^ 32'h5B);
            wr(8'(32 + i), ~(i * 32'h9E3779B9));
        end
        for (int i = 0; i < 32; i++) begin
            rd(8'(i), v);
            check("R1 mode readback", v, (32'hFFFFFF80 ^ (i * 32'h01010101) ^ 32'h5B) & 32'h67);
            rd(8'(32 + i), v);
            check("R1 vector readback", v, ~(i * 32'h9E3779B9));
        end
        spur = 32'h5A5A00FF;
        wr(W_SPUR, spur);
        rd(W_SPUR, v); check("R1 spurious readback", v, spur);

        // baseline: all rising edge, priority 0, lines low
        for (int i = 0; i < 32; i++) wr(8'(i), 32'h60);
        lines = '0;
        tick();
        wr(W_CLR, '1);
        rd(W_PEND, v); check("R3 clear all", v, 0);

        // R2 mask commands
        model = '0;
        x = 32'h1234ABCD;
        for (int k = 0; k < 12; k++) begin
            x = nxt(x);
            if (k % 3 == 2) begin
                wr(W_DIS, x);
                model = model & ~x;
            end else if (k == 4) begin
                wr(W_EN, 32'h0);
            end else begin
                wr(W_EN, x & nxt(x));
                model = model | (x & nxt(x));
            end
            rd(W_MASK, v); check("R2 mask command", v, model);
        end
        wr(W_DIS, 32'h0);
        rd(W_MASK, v); check("R2 zero disable ignored", v, model);
        wr(W_DIS, '1);

        // R3 set and clear
        model = '0;
        for (int k = 0; k < 8; k++) begin
            x = nxt(x);
            if (k % 2 == 0) begin wr(W_SET, x); model = model | x; end
            else begin wr(W_CLR, x); model = model & ~x; end
            rd(W_PEND, v); check("R3 set/clear", v, model);
        end
        wr(W_CLR, '1);

        // R4 edge sources
        wr(8'd3, 32'h61); wr(8'd35, 32'h300);
        wr(8'd4, 32'h22); wr(8'd36, 32'h400);
        lines[4] = 1'b1; tick(); tick();
        rd(W_PEND, v); check("R4 rising on falling type ignored", v, 0);
        lines[4] = 1'b0; lines[3] = 1'b1; tick(); tick();
        rd(W_PEND, v); check("R4 edges latched", v, 32'h18);
        wr(W_EN, 32'h18);
        rd(W_ACK, v);  check("R4 falling-edge winner", v, 32'h400);
        rd(W_PEND, v); check("R4 ack clears edge", v, 32'h08);
        wr(W_EOI, 0);
        rd(W_ACK, v);  check("R4 rising-edge winner", v, 32'h300);
        rd(W_PEND, v); check("R4 cleared while line high", v, 0);
        wr(W_EOI, 0);
        lines[3] = 1'b0;
        wr(W_DIS, 32'h18);

        // R5 level sources
        wr(8'd9, 32'h43); wr(8'd41, 32'h900);
        lines[9] = 1'b1; tick();
        rd(W_PEND, v); check("R5 high level pending", v, 32'h200);
        wr(W_EN, 32'h200);
        rd(W_ACK, v);  check("R5 level ack vector", v, 32'h900);
        rd(W_PEND, v); check("R5 level survives ack", v, 32'h200);
        wr(W_EOI, 0);
        lines[9] = 1'b0; tick();
        rd(W_PEND, v); check("R5 level follows line", v, 0);
        check("R5 irq_n released", {31'b0, irq_n}, 32'h1);
        wr(W_DIS, 32'h200);
        wr(8'd10, 32'h00);
        rd(W_PEND, v); check("R5 low level pending", v, 32'h400);
        lines[10] = 1'b1; tick();
        rd(W_PEND, v); check("R5 low level released", v, 0);
        wr(8'd9, 32'h60); wr(8'd10, 32'h60);
        lines[10] = 1'b0; tick();

        // R6 / R7 / R10 arbitration sweep
        for (int i = 0; i < 32; i++) begin
            wr(8'(i), 32'h60 | 32'(pr(i)));
            wr(8'(32 + i), 32'h100 + 32'(i));
        end
        wr(W_CLR, '1);
        wr(W_EN, '1);
        x = 32'hC0FFEE11;
        for (int k = 0; k < 48; k++) begin
            x = nxt(x);
            pat = (k % 6 == 0) ? 32'h0 : ((k % 3 == 1) ? (x & nxt(x) & (x >> 5)) : x);
            wr(W_SET, pat);
            w = winner(pat, '1);
            check("R7 request", {31'b0, irq_n}, (pat == 0) ? 32'h1 : 32'h0);
            rd(W_ACK, v);
            check("R6 vector of winner", v, (w < 0) ? spur : 32'h100 + 32'(w));
            rd(W_CUR, v);
            check("R8 in-service number", v, (w < 0) ? 32'h0 : 32'(w));
            rd(W_PEND, v);
            check("R4 winner cleared", v, (w < 0) ? pat : (pat & ~(32'h1 << w)));
            wr(W_EOI, 0);
            wr(W_CLR, '1);
        end

        // R6 explicit tie: sources 6 and 14 share priority 1
        wr(W_SET, 32'h4040);
        rd(W_ACK, v); check("R6 tie lower index", v, 32'h106);
        wr(W_EOI, 0);
        wr(W_CLR, '1);

        // R7 / R8 / R9 nesting
        for (int p = 0; p < 8; p++)
            for (int i = 7; i >= 0; i--)
                if (pr(i) == p) src_of[p] = i;
        for (int p = 0; p < 8; p++) begin
            wr(W_SET, 32'h1 << src_of[p]);
            check("R7 higher level requests", {31'b0, irq_n}, 32'h0);
            rd(W_ACK, v); check("R8 nested vector", v, 32'h100 + 32'(src_of[p]));
            rd(W_CUR, v); check("R8 nested in-service", v, 32'(src_of[p]));
        end
        s7b = src_of[7] + 8;
        wr(W_SET, 32'h1 << s7b);
        check("R7 equal priority blocked", {31'b0, irq_n}, 32'h1);
        rd(W_ACK, v); check("R10 spurious when full", v, spur);
        rd(W_CUR, v); check("R10 no push", v, 32'(src_of[7]));
        wr(W_EOI, 0);
        rd(W_CUR, v); check("R9 pop one level", v, 32'(src_of[6]));
        check("R7 request after pop", {31'b0, irq_n}, 32'h0);
        for (int k = 0; k < 7; k++) wr(W_EOI, 0);
        rd(W_CUR, v); check("R9 empty after eight", v, 0);
        rd(W_ACK, v); check("R9 unlocked ack", v, 32'h100 + 32'(s7b));
        wr(W_EOI, 0);
        for (int k = 0; k < 3; k++) wr(W_EOI, 32'h12345678);
        rd(W_CUR, v);  check("R9 idle eoi no effect", v, 0);
        rd(W_MASK, v); check("R9 idle eoi mask intact", v, '1);
        check("R9 idle irq_n", {31'b0, irq_n}, 32'h1);

        // partial stack then eight EOIs
        wr(W_SET, 32'h1 << src_of[1]); rd(W_ACK, v);
        wr(W_SET, 32'h1 << src_of[4]); rd(W_ACK, v);
        wr(W_SET, 32'h1 << src_of[6]); rd(W_ACK, v);
        rd(W_CUR, v); check("R8 three deep", v, 32'(src_of[6]));
        for (int k = 0; k < 8; k++) wr(W_EOI, 0);
        rd(W_CUR, v); check("R9 eight eoi from partial", v, 0);
        wr(W_SET, 32'h1 << src_of[0]);
        check("R9 lowest priority requests again", {31'b0, irq_n}, 32'h0);
        rd(W_ACK, v); check("R9 lowest priority served", v, 32'h100 + 32'(src_of[0]));
        wr(W_EOI, 0);
        wr(W_CLR, '1);

        // R2 masked source
        wr(W_DIS, 32'h20);
        wr(W_SET, 32'h20);
        check("R2 masked no request", {31'b0, irq_n}, 32'h1);
        rd(W_ACK, v); check("R2 masked ack spurious", v, spur);
        wr(W_EN, 32'h20);
        check("R2 unmasked request", {31'b0, irq_n}, 32'h0);
        rd(W_ACK, v); check("R2 unmasked vector", v, 32'h105);
        wr(W_EOI, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule